// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates an unsigned operand in two's complement form, one bit per clock, with no adder. A start strobe loads the operand into a shift register. The block then clears a step counter and a completion flag. On each following cycle the register moves right by one place, and a computed bit enters at the most significant end. That bit is the examined least significant bit, copied unchanged until the first 1 has been seen (that 1 included) and inverted after it.

A Moore-style controller has four states: idle, copy, invert and finished. Its shift and invert controls depend only on its state. After exactly `DATA_W` steps the register holds the negated value and the completion flag rises. Both stay put until the next start. The register, counter and flag are visible on every cycle, so every partial result can be observed.

Top module: `serial_negator`

## Requirements
- R1: While `arst` is high, and after it is released with no start, `value_q` is 0, `step_q` is 0 and `ready_o` is 0.
- R2: A cycle with `start` high while the block is idle or finished loads `operand` into `value_q`, sets `step_q` to 0 and clears `ready_o`. These values are visible after that clock edge.
- R3: On each processing step `value_q` shifts right by one bit position. Bit 7 receives the new computed bit, and bits 6..0 take the old bits 7..1.
- R4: The computed bit equals the examined bit 0 until a step examines a 1, that step included. Every later step inserts the inverse of the examined bit.
- R5: `step_q` increases by one on each step. After the 8th step it wraps to 0, and `ready_o` rises exactly 8 cycles after the load edge.
- R6: When `ready_o` rises, `value_q` equals (256 - operand) mod 256. An operand of 0x00 gives 0x00 and 0x80 gives 0x80, each still after 8 steps.
- R7: Once `ready_o` is high, `value_q`, `step_q` and `ready_o` stay unchanged until the next start.
- R8: A start during the 8 processing steps has no effect: the sequence and the final result are those of the operand loaded first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst | input | 1 | Asynchronous reset, active high |
| operand | input | 8 | Value to negate, sampled on start |
| start | input | 1 | Load strobe, honoured only when idle or finished |
| value_q | output | 8 | Shift register contents |
| step_q | output | 3 | Processing step counter |
| ready_o | output | 1 | Completion flag |

## Verification
The hardest condition to reach is a start strobe that arrives mid-run, because it must be ignored without disturbing the operand that is being shifted. The bench issues a second start with a different operand part-way through a run. It then checks the partial register values on each remaining step and compares the final result with the first operand. Every one of the 256 operands is run, and the register is compared with its predicted partial value after every step. This covers the point where copying gives way to inversion, at every bit position, including the all-zero and top-bit-only operands.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COPY   = 2'd1,
      ST_INVERT = 2'd2,
      ST_FIN    = 2'd3
   } neg_state_e;

endpackage

// File: rtl/neg_shreg.sv
module neg_shreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] load_val,
   input  logic              ins_bit,
   output logic [DATA_W-1:0] q
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_stage
      logic nxt;
      if (b == DATA_W - 1) begin : g_top
         assign nxt = ins_bit;
      end else begin : g_mid
         assign nxt = q[b+1];
      end
      always_ff @(posedge clk or posedge arst) begin
         if (arst)       q[b] <= 1'b0;
         else if (load)  q[b] <= load_val[b];
         else if (shift) q[b] <= nxt;
      end
   end

endmodule

// File: rtl/neg_stepcnt.sv
module neg_stepcnt #(
   parameter int STEPS = 8,
   localparam int CW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic          clk,
   input  logic          arst,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt,
   output logic          last
);

   localparam logic [CW-1:0] LAST_VAL = CW'(STEPS - 1);

   assign last = (cnt == LAST_VAL);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)      cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (inc)  cnt <= last ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/neg_ctrl.sv
module neg_ctrl
   import serial_negator_pkg::*;
(
   input  logic clk,
   input  logic arst,
   input  logic start,
   input  logic lsb,
   input  logic last,
   output logic load,
   output logic shift,
   output logic inv_mode,
   output logic finish
);

   neg_state_e state, state_n;

   // Moore controls: decoded from state only
   assign shift    = (state == ST_COPY) || (state == ST_INVERT);
   assign inv_mode = (state == ST_INVERT);
   assign load     = start && ((state == ST_IDLE) || (state == ST_FIN));
   assign finish   = shift && last;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE, ST_FIN: if (start) state_n = ST_COPY;
         ST_COPY: begin
            if (last)     state_n = ST_FIN;
            else if (lsb) state_n = ST_INVERT;
         end
         ST_INVERT: if (last) state_n = ST_FIN;
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) state <= ST_IDLE;
      else      state <= state_n;
   end

endmodule

// File: rtl/serial_negator.sv
module serial_negator #(
   parameter int DATA_W = 8,
   localparam int CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              arst,
   input  logic [DATA_W-1:0] operand,
   input  logic              start,
   output logic [DATA_W-1:0] value_q,
   output logic [CW-1:0]     step_q,
   output logic              ready_o
);

   if (DATA_W < 2) begin : g_chk_w
      $error("serial_negator: DATA_W must be at least 2");
   end

   logic load, shift, inv_mode, finish, last, ins_bit;

   neg_ctrl u_ctrl (
      .clk      (clk),
      .arst     (arst),
      .start    (start),
      .lsb      (value_q[0]),
      .last     (last),
      .load     (load),
      .shift    (shift),
      .inv_mode (inv_mode),
      .finish   (finish)
   );

   assign ins_bit = value_q[0] ^ inv_mode;

   neg_shreg #(.DATA_W(DATA_W)) u_shreg (
      .clk      (clk),
      .arst     (arst),
      .load     (load),
      .shift    (shift),
      .load_val (operand),
      .ins_bit  (ins_bit),
      .q        (value_q)
   );

   neg_stepcnt #(.STEPS(DATA_W)) u_cnt (
      .clk  (clk),
      .arst (arst),
      .clr  (load),
      .inc  (shift),
      .cnt  (step_q),
      .last (last)
   );

   always_ff @(posedge clk or posedge arst) begin
      if (arst)        ready_o <= 1'b0;
      else if (load)   ready_o <= 1'b0;
      else if (finish) ready_o <= 1'b1;
   end

endmodule

// File: rtl/serial_negator_chk.sv
module serial_negator_chk #(
   parameter int DATA_W = 8,
   localparam int CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input logic              clk,
   input logic              arst,
   input logic [DATA_W-1:0] operand,
   input logic              start,
   input logic [DATA_W-1:0] value_q,
   input logic [CW-1:0]     step_q,
   input logic              ready_o,
   input logic              shift,
   input logic              inv_mode,
   input logic              load
);

   p_load_r2: assert property (@(posedge clk) disable iff (arst)
      load |=> (value_q == $past(operand)) && (step_q == '0) && !ready_o);

   p_shift_r3: assert property (@(posedge clk) disable iff (arst)
      shift |=> value_q[DATA_W-2:0] == $past(value_q[DATA_W-1:1]));

   p_copy_r4: assert property (@(posedge clk) disable iff (arst)
      (shift && !inv_mode) |=> value_q[DATA_W-1] == $past(value_q[0]));

   p_invert_r4: assert property (@(posedge clk) disable iff (arst)
      (shift && inv_mode) |=> value_q[DATA_W-1] != $past(value_q[0]));

   p_ready_r5: assert property (@(posedge clk) disable iff (arst)
      $rose(ready_o) |-> (step_q == '0) && !shift);

   p_hold_r7: assert property (@(posedge clk) disable iff (arst)
      (ready_o && !start) |=> ready_o && $stable(value_q) && $stable(step_q));

   p_busy_start_r8: assert property (@(posedge clk) disable iff (arst)
      (shift && start) |-> !load);

endmodule

bind serial_negator serial_negator_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .arst     (arst),
   .operand  (operand),
   .start    (start),
   .value_q  (value_q),
   .step_q   (step_q),
   .ready_o  (ready_o),
   .shift    (shift),
   .inv_mode (inv_mode),
   .load     (load)
);

// File: tb/test_serial_negator.sv
`timescale 1ns/1ps
module test_serial_negator;

   logic       clk = 1'b0;
   logic       arst = 1'b1;
   logic [7:0] operand = 8'h00;
   logic       start = 1'b0;
   logic [7:0] value_q;
   logic [2:0] step_q;
   logic       ready_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   serial_negator i_serial_negator (
      .clk     (clk),
      .arst    (arst),
      .operand (operand),
      .start   (start),
      .value_q (value_q),
      .step_q  (step_q),
      .ready_o (ready_o)
   );

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // value after j steps: low j result bits on top, remaining operand bits below
   function automatic logic [7:0] partial(input logic [7:0] op, input int j);
      logic [7:0] res = 8'(-op);
      if (j == 0) return op;
      if (j >= 8) return res;
      return 8'((res << (8 - j)) | (op >> j));
   endfunction

   // run one operand; optionally pulse start with other value at step busy_at
   task automatic run(input logic [7:0] op, input int busy_at, input logic [7:0] other);
      operand = op;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      check("R2 load", {value_q, step_q, ready_o}, {op, 3'd0, 1'b0});
      for (int j = 1; j <= 8; j++) begin
         if (j - 1 == busy_at) begin
            operand = other;
            start   = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         if (j < 8) begin
            check("R3 R4 partial shift", {value_q, step_q, ready_o},
                  {partial(op, j), 3'(j), 1'b0});
         end else begin
            check("R5 R6 result", {value_q, step_q, ready_o}, {8'(-op), 3'd0, 1'b1});
         end
      end
   endtask

   initial begin
      #200000000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #12;
      check("R1 reset held", {value_q, step_q, ready_o}, 12'h000);
      @(negedge clk);
      arst = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R1 after release", {value_q, step_q, ready_o}, 12'h000);

      // R6 corner operands
      run(8'h00, -1, 8'h00);
      run(8'h80, -1, 8'h00);
      run(8'h01, -1, 8'h00);
      run(8'hFF, -1, 8'h00);

      // exhaustive sweep, back to back from finished state
      for (int v = 0; v < 256; v++) run(8'(v), -1, 8'h00);

      // R7 hold after completion
      run(8'h36, -1, 8'h00);
      operand = 8'hA5;
      repeat (5) @(negedge clk);
      check("R7 hold", {value_q, step_q, ready_o}, {8'hCA, 3'd0, 1'b1});

      // R8 start while busy at several steps
      for (int s = 1; s < 8; s++) run(8'h2C + 8'(s), s, 8'h5A);
      run(8'h80, 3, 8'h01);
      operand = 8'h77;
      repeat (3) @(negedge clk);
      check("R8 R7 final after busy start", {value_q, step_q, ready_o}, {8'h80, 3'd0, 1'b1});

      // R1 asynchronous reset mid-run
      operand = 8'h13;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      #2 arst = 1'b1;
      #1 check("R1 async mid-run", {value_q, step_q, ready_o}, 12'h000);
      @(negedge clk);
      arst = 1'b0;
      run(8'h13, -1, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule